// File: doc/BRIEF.md
# Peer Setup Message Processor

This block sits behind the byte channel that links a node to a coordination server. It assembles the bytes into 64-bit signed messages, least significant byte first. Each message is paired with a flag that says whether a side-band handle arrived with its final byte. Each message is classified from its value and that flag. The block drives a fixed handshake. The first message is a version check and the second assigns the node its own ID. A run of peer messages then follows, ending with the shared-memory announcement (value -1).

After setup the block keeps accepting two kinds of peer message. A connect (non-negative value with a handle) bumps that peer's registered vector count. Vector numbers are never sent; they are inferred from how many connects a peer has made. A disconnect (non-negative value without a handle) clears the count. The block tracks how many peer slots are in use, growing that figure as higher peer indices appear, inside a fixed on-chip table. Every rejected message produces a one-cycle error pulse with a reason code.

Top module: `peer_setup_proc`

## Requirements
- R1: After synchronous reset, own_id is 0, is_master and shm_ready are 0, peer_cap equals INIT_CAP (16), every vector count is 0 and err_valid is 0 with err_code 0.
- R2: Bytes are taken least significant first. The handle flag is taken with the eighth byte. A message is acted on at the clock edge after the one that accepted its eighth byte, and the byte counter then restarts.
- R3: The first message must equal PROTO_VER and carry no handle. Otherwise err_code 1 is pulsed and the block ignores every later message until reset.
- R4: The second message must carry no handle and lie in 0..65535; it becomes own_id. Otherwise err_code 2 is pulsed and the block halts as in R3.
- R5: master_sel encodes 0 = slave, 1 = master, 2 = automatic. With master_sel 1 an own ID other than 0 pulses err_code 3 and halts the block. Otherwise is_master becomes 1 for master_sel 1, or for master_sel 2 with own ID 0, and 0 in all other cases.
- R6: A message of value -1 sets shm_ready, which then stays set, and ends setup. A further -1 while shm_ready is set pulses err_code 5.
- R7: A message below -1 or above 65535, after the ID, pulses err_code 4 and changes no table state.
- R8: A connect raises that peer's count by one. When the count already equals NUM_VECTORS (4) the connect pulses err_code 7 and the count is unchanged.
- R9: A disconnect clears that peer's count to 0. A disconnect naming own_id pulses err_code 8 and leaves the count unchanged.
- R10: A peer message naming index p >= peer_cap sets peer_cap to p+1. If p >= TABLE_DEPTH (32), err_code 6 is pulsed and neither peer_cap nor any count changes.
- R11: Any error between the ID and the first -1 halts the block, so later messages, including -1, have no effect. After setup has completed, errors do not halt processing.
- R12: err_valid is high for exactly one cycle per rejected message with a non-zero err_code, and err_code is 0 whenever err_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A byte is present on rx_byte |
| rx_byte | input | 8 | Byte from the server channel |
| rx_handle | input | 1 | A handle accompanies the message; sampled with its eighth byte |
| master_sel | input | 2 | 0 slave, 1 master, 2 automatic |
| own_id | output | 16 | Own ID taken from the second message |
| is_master | output | 1 | Resolved master status |
| shm_ready | output | 1 | Shared memory has been announced |
| peer_cap | output | $clog2(TABLE_DEPTH+1) | Number of peer slots in use |
| vec_counts | output | TABLE_DEPTH*$clog2(NUM_VECTORS+1) | Per-peer vector counts, peer p in slice p |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 4 | Reason for the current error pulse |

## Verification
A byte counter out of step shows up at once: the very next message is decoded with shifted bytes. That gives a wrong own_id or a version error one cycle after the supposed eighth byte. A wrong handshake phase shows as errors that should not fire, or as messages that are silently dropped. It therefore becomes visible on the first message after the fault. A corrupted count or capacity stays hidden until that peer is next touched. The reference model compares the whole table and capacity on every clock, so such a fault is reported in the cycle it is written, not only when it is used.

// File: rtl/psp_pkg.sv
package psp_pkg;

    localparam int ID_W = 16;

    typedef enum logic [3:0] {
        ERR_NONE       = 4'd0,
        ERR_VERSION    = 4'd1,
        ERR_ID         = 4'd2,
        ERR_MASTER     = 4'd3,
        ERR_RANGE      = 4'd4,
        ERR_SHM_DUP    = 4'd5,
        ERR_TABLE_FULL = 4'd6,
        ERR_VEC_FULL   = 4'd7,
        ERR_SELF_DROP  = 4'd8
    } err_e;

    typedef enum logic [1:0] {
        MST_OFF  = 2'd0,
        MST_ON   = 2'd1,
        MST_AUTO = 2'd2
    } mst_e;

    typedef enum logic [2:0] {
        PH_VERSION,
        PH_ID,
        PH_SETUP,
        PH_RUN,
        PH_HALT
    } phase_e;

    typedef enum logic [1:0] {
        K_INVALID,
        K_SHM,
        K_CONNECT,
        K_DISCONNECT
    } kind_e;

    typedef struct packed {
        logic [63:0] value;
        logic        handle;
    } msg_t;

    // true when the signed 64-bit value lies in 0..65535
    function automatic logic fits_id(input logic [63:0] v);
        return !v[63] && (v[62:ID_W] == '0);
    endfunction

endpackage

// File: rtl/psp_byte_assembler.sv
module psp_byte_assembler
    import psp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic [7:0] in_byte,
    input  logic in_handle,
    output msg_t msg,
    output logic msg_valid
);
    logic [2:0]  byte_idx;
    logic [55:0] partial;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_idx  <= '0;
            partial   <= '0;
            msg       <= '0;
            msg_valid <= 1'b0;
        end else begin
            msg_valid <= 1'b0;
            if (in_valid) begin
                if (byte_idx == 3'd7) begin
                    msg.value  <= {in_byte, partial};
                    msg.handle <= in_handle;
                    msg_valid  <= 1'b1;
                    byte_idx   <= '0;
                end else begin
                    partial  <= {in_byte, partial[55:8]};
                    byte_idx <= byte_idx + 3'd1;
                end
            end
        end
    end
endmodule

// File: rtl/psp_msg_classifier.sv
module psp_msg_classifier
    import psp_pkg::*;
(
    input  msg_t msg,
    output kind_e kind,
    output logic [ID_W-1:0] peer
);
    always_comb begin
        peer = msg.value[ID_W-1:0];
        if (msg.value == '1)
            kind = K_SHM;
        else if (!fits_id(msg.value))
            kind = K_INVALID;
        else if (msg.handle)
            kind = K_CONNECT;
        else
            kind = K_DISCONNECT;
    end
endmodule

// File: rtl/psp_peer_table.sv
module psp_peer_table
    import psp_pkg::*;
#(
    parameter int TABLE_DEPTH = 32,
    parameter int NUM_VECTORS = 4,
    parameter int INIT_CAP    = 16,
    localparam int IDXW = $clog2(TABLE_DEPTH),
    localparam int CAPW = $clog2(TABLE_DEPTH + 1),
    localparam int CW   = $clog2(NUM_VECTORS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic is_connect,
    input  logic [ID_W-1:0] peer,
    input  logic [ID_W-1:0] own_id,
    output err_e result,
    output logic [CAPW-1:0] cap,
    output logic [TABLE_DEPTH*CW-1:0] counts_flat
);
    logic [CW-1:0]   cnt [TABLE_DEPTH];
    logic            in_range;
    logic            need_grow;
    logic [IDXW-1:0] idx;
    logic [CW-1:0]   cur;

    always_comb begin
        in_range  = 32'(peer) < TABLE_DEPTH;
        idx       = peer[IDXW-1:0];
        cur       = in_range ? cnt[idx] : '0;
        need_grow = in_range && (32'(peer) >= 32'(cap));
        if (!in_range)
            result = ERR_TABLE_FULL;
        else if (is_connect && 32'(cur) >= NUM_VECTORS)
            result = ERR_VEC_FULL;
        else if (!is_connect && peer == own_id)
            result = ERR_SELF_DROP;
        else
            result = ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= CAPW'(INIT_CAP);
            for (int i = 0; i < TABLE_DEPTH; i++) cnt[i] <= '0;
        end else if (req) begin
            // capacity follows any in-table index, even if the op is refused
            if (need_grow)
                cap <= CAPW'(32'(peer) + 1);
            if (result == ERR_NONE)
                cnt[idx] <= is_connect ? cur + CW'(1) : '0;
        end
    end

    for (genvar g = 0; g < TABLE_DEPTH; g++) begin : g_flat
        assign counts_flat[g*CW +: CW] = cnt[g];
    end
endmodule

// File: rtl/peer_setup_proc.sv
module peer_setup_proc
    import psp_pkg::*;
#(
    parameter logic [63:0] PROTO_VER   = 64'd0,
    parameter int          TABLE_DEPTH = 32,
    parameter int          NUM_VECTORS = 4,
    parameter int          INIT_CAP    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_valid,
    input  logic [7:0] rx_byte,
    input  logic rx_handle,
    input  logic [1:0] master_sel,
    output logic [15:0] own_id,
    output logic is_master,
    output logic shm_ready,
    output logic [$clog2(TABLE_DEPTH+1)-1:0] peer_cap,
    output logic [TABLE_DEPTH*$clog2(NUM_VECTORS+1)-1:0] vec_counts,
    output logic err_valid,
    output logic [3:0] err_code
);
    msg_t            msg;
    logic            msg_valid;
    kind_e           kind;
    logic [ID_W-1:0] peer;
    phase_e          phase;
    err_e            tbl_res;
    err_e            op_err;
    logic            active;
    logic            tbl_req;

    psp_byte_assembler u_asm (
        .clk(clk), .rst(rst), .in_valid(rx_valid), .in_byte(rx_byte),
        .in_handle(rx_handle), .msg(msg), .msg_valid(msg_valid)
    );

    psp_msg_classifier u_cls (.msg(msg), .kind(kind), .peer(peer));

    psp_peer_table #(
        .TABLE_DEPTH(TABLE_DEPTH), .NUM_VECTORS(NUM_VECTORS), .INIT_CAP(INIT_CAP)
    ) u_tbl (
        .clk(clk), .rst(rst), .req(tbl_req), .is_connect(kind == K_CONNECT),
        .peer(peer), .own_id(own_id), .result(tbl_res), .cap(peer_cap),
        .counts_flat(vec_counts)
    );

    always_comb begin
        active  = (phase == PH_SETUP) || (phase == PH_RUN);
        tbl_req = msg_valid && active && (kind == K_CONNECT || kind == K_DISCONNECT);
        unique case (kind)
            K_INVALID: op_err = ERR_RANGE;
            K_SHM:     op_err = shm_ready ? ERR_SHM_DUP : ERR_NONE;
            default:   op_err = tbl_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_VERSION;
            own_id    <= '0;
            is_master <= 1'b0;
            shm_ready <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
            if (msg_valid) begin
                case (phase)
                    PH_VERSION: begin
                        if (msg.value == PROTO_VER && !msg.handle) begin
                            phase <= PH_ID;
                        end else begin
                            phase <= PH_HALT; err_valid <= 1'b1; err_code <= ERR_VERSION;
                        end
                    end
                    PH_ID: begin
                        if (!msg.handle && fits_id(msg.value)) begin
                            own_id <= peer;
                            if (master_sel == MST_ON && peer != '0) begin
                                phase <= PH_HALT; err_valid <= 1'b1; err_code <= ERR_MASTER;
                            end else begin
                                phase     <= PH_SETUP;
                                is_master <= (master_sel == MST_ON) ||
                                             (master_sel == MST_AUTO && peer == '0);
                            end
                        end else begin
                            phase <= PH_HALT; err_valid <= 1'b1; err_code <= ERR_ID;
                        end
                    end
                    PH_SETUP, PH_RUN: begin
                        if (op_err != ERR_NONE) begin
                            err_valid <= 1'b1;
                            err_code  <= op_err;
                            if (phase == PH_SETUP) phase <= PH_HALT;
                        end else if (kind == K_SHM) begin
                            shm_ready <= 1'b1;
                            phase     <= PH_RUN;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/psp_checker.sv
module psp_checker #(
    parameter int TABLE_DEPTH = 32,
    parameter int NUM_VECTORS = 4,
    parameter int INIT_CAP    = 16,
    localparam int CAPW = $clog2(TABLE_DEPTH + 1),
    localparam int CW   = $clog2(NUM_VECTORS + 1)
) (
    input logic clk,
    input logic rst,
    input logic [15:0] own_id,
    input logic shm_ready,
    input logic [CAPW-1:0] peer_cap,
    input logic [TABLE_DEPTH*CW-1:0] vec_counts,
    input logic err_valid,
    input logic [3:0] err_code
);
    assert_err_single_R12: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);

    assert_err_code_R12: assert property (@(posedge clk) disable iff (rst)
        err_valid == (err_code != 4'd0));

    assert_shm_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        shm_ready |=> shm_ready);

    assert_dup_needs_shm_R6: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_code == 4'd5) |-> shm_ready);

    assert_id_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        shm_ready |=> $stable(own_id));

    assert_cap_bounds_R10: assert property (@(posedge clk) disable iff (rst)
        (32'(peer_cap) >= INIT_CAP) && (32'(peer_cap) <= TABLE_DEPTH));

    for (genvar g = 0; g < TABLE_DEPTH; g++) begin : g_cnt
        assert_cnt_limit_R8: assert property (@(posedge clk) disable iff (rst)
            32'(vec_counts[g*CW +: CW]) <= NUM_VECTORS);
    end
endmodule

bind peer_setup_proc psp_checker #(
    .TABLE_DEPTH(TABLE_DEPTH), .NUM_VECTORS(NUM_VECTORS), .INIT_CAP(INIT_CAP)
) u_chk (
    .clk(clk), .rst(rst), .own_id(own_id), .shm_ready(shm_ready),
    .peer_cap(peer_cap), .vec_counts(vec_counts),
    .err_valid(err_valid), .err_code(err_code)
);

// File: tb/peer_setup_proc_tb.sv
`timescale 1ns/1ps
module peer_setup_proc_tb;
    localparam int DEPTH = 32;
    localparam int NV    = 4;
    localparam int CW    = 3;
    localparam int CAPW  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_handle = 1'b0;
    logic [1:0] master_sel = 2'd0;
    logic [15:0] own_id;
    logic is_master, shm_ready, err_valid;
    logic [CAPW-1:0] peer_cap;
    logic [DEPTH*CW-1:0] vec_counts;
    logic [3:0] err_code;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    peer_setup_proc u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_handle(rx_handle), .master_sel(master_sel), .own_id(own_id),
        .is_master(is_master), .shm_ready(shm_ready), .peer_cap(peer_cap),
        .vec_counts(vec_counts), .err_valid(err_valid), .err_code(err_code)
    );

    // ---------------- behavioural reference model ----------------
    int          m_phase;      // 0 version, 1 id, 2 setup, 3 run, 4 halted
    int          m_id, m_cap, m_ec, m_bc;
    bit          m_mst, m_shm, m_ev, m_pend, m_ph;
    int          m_cnt [DEPTH];
    logic [63:0] m_buf, m_pv;

    task automatic model_msg(input logic [63:0] v, input bit h);
        longint sv = longint'(v);
        int e = 0;
        case (m_phase)
            0: if (v == 64'd0 && !h) m_phase = 1; else begin e = 1; m_phase = 4; end
            1: if (!h && sv >= 0 && sv <= 65535) begin
                   m_id = int'(sv);
                   if (master_sel == 2'd1 && sv != 0) begin e = 3; m_phase = 4; end
                   else begin
                       m_phase = 2;
                       m_mst = (master_sel == 2'd1) || (master_sel == 2'd2 && sv == 0);
                   end
               end else begin e = 2; m_phase = 4; end
            2, 3: begin
                if (sv < -1 || sv > 65535) e = 4;
                else if (sv == -1) e = m_shm ? 5 : 0;
                else begin
                    int p = int'(sv);
                    if (p >= DEPTH) e = 6;
                    else begin
                        if (p >= m_cap) m_cap = p + 1;
                        if (h) begin
                            if (m_cnt[p] >= NV) e = 7; else m_cnt[p]++;
                        end else begin
                            if (p == m_id) e = 8; else m_cnt[p] = 0;
                        end
                    end
                end
                if (e != 0) begin if (m_phase == 2) m_phase = 4; end
                else if (sv == -1) begin m_shm = 1; m_phase = 3; end
            end
            default: ;
        endcase
        if (e != 0) begin m_ev = 1; m_ec = e; end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_id = 0; m_cap = 16; m_ec = 0; m_bc = 0;
            m_mst = 0; m_shm = 0; m_ev = 0; m_pend = 0; m_ph = 0;
            m_buf = '0; m_pv = '0;
            for (int i = 0; i < DEPTH; i++) m_cnt[i] = 0;
        end else begin
            m_ev = 0; m_ec = 0;
            if (m_pend) begin model_msg(m_pv, m_ph); m_pend = 0; end
            if (rx_valid) begin
                m_buf[m_bc*8 +: 8] = rx_byte;
                m_bc++;
                if (m_bc == 8) begin m_pend = 1; m_pv = m_buf; m_ph = rx_handle; m_bc = 0; end
            end
        end
    end

    function automatic string tag_of(input int code);
        case (code)
            1: return "R3";  2: return "R4";  3: return "R5";  4: return "R7";
            5: return "R6";  6: return "R10"; 7: return "R8";  8: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [DEPTH*CW-1:0] ev;
            for (int i = 0; i < DEPTH; i++) ev[i*CW +: CW] = CW'(m_cnt[i]);
            chk("R4 own_id", own_id, m_id);
            chk("R5 is_master", is_master, m_mst);
            chk("R6 shm_ready", shm_ready, m_shm);
            chk("R10 peer_cap", peer_cap, m_cap);
            tests++;
            if (vec_counts !== ev) begin
                fails++;
                $display("FAIL R8 R9 vec_counts: actual %h expected %h", vec_counts, ev);
            end
            chk({tag_of(m_ec), " err_valid"}, err_valid, m_ev);
            chk({tag_of(m_ec), " err_code"}, err_code, m_ec);
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input logic [1:0] ms);
        @(negedge clk); rst = 1'b1; master_sel = ms;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // returns at the first negedge where the message's effect is visible
    task automatic send(input longint v, input bit h);
        logic [63:0] u = v;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_byte = u[i*8 +: 8]; rx_handle = (i == 7) ? h : 1'b0;
        end
        @(negedge clk); rx_valid = 1'b0; rx_handle = 1'b0;
        @(negedge clk);
    endtask

    function automatic int cnt_of(input int p);
        return int'(vec_counts[p*CW +: CW]);
    endfunction

    initial begin
        do_reset(2'd2);
        // R1 reset state
        chk("R1 own_id", own_id, 0);
        chk("R1 shm_ready", shm_ready, 0);
        chk("R1 is_master", is_master, 0);
        chk("R1 peer_cap", peer_cap, 16);
        chk("R1 counts", (vec_counts == '0), 1);
        chk("R1 err_valid", err_valid, 0);

        // R3 wrong version, then halted
        send(1, 0);
        chk("R3 err_code", err_code, 1);
        send(0, 0); send(5, 0);
        chk("R3 halted own_id", own_id, 0);
        do_reset(2'd2);
        send(0, 1);
        chk("R3 handle err", err_code, 1);

        // R4 bad ID
        do_reset(2'd2);
        send(0, 0); send(3, 1);
        chk("R4 handle on id", err_code, 2);
        do_reset(2'd2);
        send(0, 0); send(70000, 0);
        chk("R4 id range", err_code, 2);

        // R2 byte order
        do_reset(2'd0);
        send(0, 0); send(64'h0102, 0);
        chk("R2 own_id lsb first", own_id, 258);
        chk("R5 slave", is_master, 0);

        // R5 master rules
        do_reset(2'd1);
        send(0, 0); send(3, 0);
        chk("R5 master nonzero", err_code, 3);
        do_reset(2'd1);
        send(0, 0); send(0, 0);
        chk("R5 master zero", is_master, 1);
        do_reset(2'd2);
        send(0, 0); send(5, 0);
        chk("R5 auto nonzero", is_master, 0);

        // main run, automatic, own ID 9
        do_reset(2'd2);
        send(0, 0); send(0, 0);
        chk("R5 auto zero", is_master, 1);
        do_reset(2'd2);
        send(0, 0); send(9, 0);
        for (int k = 0; k < 3; k++) send(0, 1);
        chk("R8 three connects", cnt_of(0), 3);
        send(20, 1);
        chk("R10 grow", peer_cap, 21);
        send(-1, 0);
        chk("R6 shm", shm_ready, 1);
        send(0, 1);
        chk("R8 fourth", cnt_of(0), 4);
        send(0, 1);
        chk("R8 full err", err_code, 7);
        chk("R8 unchanged", cnt_of(0), 4);
        @(negedge clk);
        chk("R12 single pulse", err_valid, 0);
        send(-1, 0);
        chk("R6 dup", err_code, 5);
        send(70000, 1);
        chk("R7 high", err_code, 4);
        send(-5, 0);
        chk("R7 low", err_code, 4);
        send(0, 0);
        chk("R9 disconnect", cnt_of(0), 0);
        send(9, 1);
        send(9, 0);
        chk("R9 self err", err_code, 8);
        chk("R9 self kept", cnt_of(9), 1);
        send(3, 1);
        chk("R11 still running", cnt_of(3), 1);
        send(40, 1);
        chk("R10 full err", err_code, 6);
        chk("R10 cap kept", peer_cap, 21);
        send(31, 1);
        chk("R10 cap max", peer_cap, 32);

        // R11 error during setup halts
        do_reset(2'd2);
        send(0, 0); send(1, 0); send(1, 0);
        chk("R11 setup err", err_code, 8);
        send(-1, 0);
        chk("R11 halted shm", shm_ready, 0);
        send(4, 1);
        chk("R11 halted table", cnt_of(4), 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule